// File: doc/BRIEF.md
# Watchdog Timer Peripheral

A memory-mapped watchdog that software must service periodically. A down-counter is loaded from a programmable reload register. It counts one step for each cycle in which the tick-enable input is high, and only while the run bit is set. To keep the timer from expiring, software writes a fixed key to the kick register, which loads the counter again.

When the count reaches zero, a sticky status flag is set. Depending on the control bits, the block also raises an interrupt level and issues a one-cycle system reset request. The clock source, the tick prescaler, the bus fabric, the interrupt controller and the reset generator all sit outside the block.

Accesses are single-cycle, full 32-bit and little-endian. A write is committed at the rising clock edge on which `bus_req` and `bus_we` are both high. Read data is driven combinationally while `bus_req` is high with `bus_we` low.

Top module: `wdog_periph`

## Requirements
- R1: After reset, the control register and the status register read 0, the reload register reads 0x03EF1480, and `wdt_irq` and `wdt_rst_req` are low.
- R2: The map uses byte addresses with bits [1:0] equal to 0. The offsets are: 0x04 reload (read/write), 0x0C control (read/write, bits [2:0] kept, upper bits read 0), 0x10 status (read-only), 0x18 interrupt length (read/write storage), 0x1C revision (reads 0x00010601). Any other or misaligned address reads 0, and writes to it are ignored.
- R3: Offset 0x00 returns the live count while control bit 0 (run) is 1, and returns the reload value while run is 0.
- R4: While running and not yet expired, the count drops by one at each edge where `tick_en` is high. It never goes below zero, and it holds at zero after expiry.
- R5: A control write with bit 0 = 1 loads the counter from the reload register only if run was 0 before the write. A control write with bit 0 = 0 stops the counter and cancels any pending expiry.
- R6: A write of exactly 0x00005AB9 to offset 0x08 while run is 1 loads the counter from the reload register. Any other value has no effect, and so does any write while run is 0.
- R7: Expiry fires once per load, in the cycle where the count sits at zero while running. Status bit 0 is set at the following edge.
- R8: When control bit 1 is 1, expiry produces a `wdt_rst_req` pulse exactly one cycle wide. The pulse is high in the same cycle in which the status flag first reads 1.
- R9: `wdt_irq` is a level equal to status bit 0 AND control bit 2.
- R10: A write to offset 0x14 with data bit 0 = 1 clears status bit 0. With data bit 0 = 0 the write has no effect. If an expiry and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-step enable from the external prescaler |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wdt_irq | output | 1 | Timeout interrupt level |
| wdt_rst_req | output | 1 | One-cycle system reset request |

## Verification
Timing of each result:
- A register write takes effect at the edge that samples it. Read data is valid in the same cycle as the request, so the bench reads back any time after the write edge.
- The counter moves one step per ticked edge after the enable or kick edge.
- The expiry event occurs in the cycle after the edge at which the count becomes zero.
- Status, interrupt and the reset pulse then appear one edge later. The reset pulse drops at the next edge.

The bench drives inputs just after a clock edge and samples half a cycle later, at the falling edge. During the expiry test it checks every falling edge, so an early or late flag, or a pulse that lasts two cycles, is caught at the exact cycle.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int WORD_W = 32;
  localparam int IX_W   = 3;
  localparam int CTL_W  = 3;

  // control bit positions
  localparam int CTL_RUN = 0;
  localparam int CTL_RST = 1;
  localparam int CTL_IRQ = 2;

  localparam logic [WORD_W-1:0] KICK_KEY  = 32'h0000_5AB9;
  localparam logic [WORD_W-1:0] REV_CODE  = 32'h0001_0601;
  localparam logic [WORD_W-1:0] RELOAD_PO = 32'h03EF_1480;

  typedef enum logic [IX_W-1:0] {
    WIX_COUNT   = 3'd0,
    WIX_RELOAD  = 3'd1,
    WIX_KICK    = 3'd2,
    WIX_CTRL    = 3'd3,
    WIX_STATUS  = 3'd4,
    WIX_SCLR    = 3'd5,
    WIX_ILEN    = 3'd6,
    WIX_REV     = 3'd7
  } word_ix_e;

  // one count step: decrement on tick, saturate at zero
  function automatic logic [WORD_W-1:0] count_step(input logic [WORD_W-1:0] c,
                                                   input logic tick);
    return (tick && (c != '0)) ? c - 1'b1 : c;
  endfunction

  function automatic logic is_kick(input logic [WORD_W-1:0] d);
    return d == KICK_KEY;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [WORD_W-1:0] RELOAD_INIT = RELOAD_PO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] reload_q,
  output logic [CTL_W-1:0]  ctrl_q,
  output logic [WORD_W-1:0] ilen_q,
  output logic [IX_W-1:0]   word_ix,
  output logic              mapped,
  output logic              start_evt,
  output logic              stop_evt,
  output logic              kick_evt,
  output logic              sclr_evt
);
  localparam int HI_W = AW - 2 - IX_W;

  logic wr_acc;
  logic wr_reload, wr_ctrl, wr_kick, wr_sclr, wr_ilen;

  assign word_ix = bus_addr[IX_W+1:2];
  generate
    if (HI_W > 0) begin : g_hi
      assign mapped = (bus_addr[1:0] == 2'b00) && (bus_addr[AW-1:IX_W+2] == '0);
    end else begin : g_nohi
      assign mapped = (bus_addr[1:0] == 2'b00);
    end
  endgenerate

  assign wr_acc    = bus_req & bus_we & mapped;
  assign wr_reload = wr_acc && (word_ix == WIX_RELOAD);
  assign wr_ctrl   = wr_acc && (word_ix == WIX_CTRL);
  assign wr_kick   = wr_acc && (word_ix == WIX_KICK);
  assign wr_sclr   = wr_acc && (word_ix == WIX_SCLR);
  assign wr_ilen   = wr_acc && (word_ix == WIX_ILEN);

  assign start_evt = wr_ctrl & bus_wdata[CTL_RUN] & ~ctrl_q[CTL_RUN];
  assign stop_evt  = wr_ctrl & ~bus_wdata[CTL_RUN];
  assign kick_evt  = wr_kick & ctrl_q[CTL_RUN] & is_kick(bus_wdata);
  assign sclr_evt  = wr_sclr & bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_INIT;
      ctrl_q   <= '0;
      ilen_q   <= '0;
    end else begin
      if (wr_reload) reload_q <= bus_wdata;
      if (wr_ctrl)   ctrl_q   <= bus_wdata[CTL_W-1:0];
      if (wr_ilen)   ilen_q   <= bus_wdata;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              load_evt,
  input  logic              stop_evt,
  input  logic [WORD_W-1:0] reload,
  output logic [WORD_W-1:0] cnt_q,
  output logic              armed_q,
  output logic              expire_evt
);
  assign expire_evt = armed_q & run & (cnt_q == '0) & ~load_evt & ~stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_evt) begin
      cnt_q   <= reload;
      armed_q <= 1'b1;
    end else if (stop_evt || expire_evt) begin
      armed_q <= 1'b0;
    end else if (run && armed_q) begin
      cnt_q   <= count_step(cnt_q, tick);
    end
  end
endmodule

// File: rtl/wdog_alarm.sv
`timescale 1ns/1ps
module wdog_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_evt,
  input  logic sclr_evt,
  input  logic rst_en,
  input  logic irq_en,
  output logic status_q,
  output logic irq,
  output logic rst_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      if (expire_evt)    status_q <= 1'b1;
      else if (sclr_evt) status_q <= 1'b0;
      rst_req <= expire_evt & rst_en;
    end
  end

  assign irq = status_q & irq_en;
endmodule

// File: rtl/wdog_periph.sv
`timescale 1ns/1ps
module wdog_periph
  import wdog_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [WORD_W-1:0] RELOAD_INIT = RELOAD_PO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  logic [WORD_W-1:0] reload_q, ilen_q, cnt_q;
  logic [CTL_W-1:0]  ctrl_q;
  logic [IX_W-1:0]   word_ix;
  logic              mapped;
  logic              start_evt, stop_evt, kick_evt, sclr_evt, load_evt;
  logic              armed, expire_evt, status_q;

  assign load_evt = start_evt | kick_evt;

  wdog_regs #(.AW(AW), .RELOAD_INIT(RELOAD_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .reload_q(reload_q), .ctrl_q(ctrl_q), .ilen_q(ilen_q),
    .word_ix(word_ix), .mapped(mapped),
    .start_evt(start_evt), .stop_evt(stop_evt), .kick_evt(kick_evt), .sclr_evt(sclr_evt)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n),
    .run(ctrl_q[CTL_RUN]), .tick(tick_en),
    .load_evt(load_evt), .stop_evt(stop_evt), .reload(reload_q),
    .cnt_q(cnt_q), .armed_q(armed), .expire_evt(expire_evt)
  );

  wdog_alarm u_alarm (
    .clk(clk), .rst_n(rst_n),
    .expire_evt(expire_evt), .sclr_evt(sclr_evt),
    .rst_en(ctrl_q[CTL_RST]), .irq_en(ctrl_q[CTL_IRQ]),
    .status_q(status_q), .irq(wdt_irq), .rst_req(wdt_rst_req)
  );

  // read path: combinational
  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_we && mapped) begin
      case (word_ix)
        WIX_COUNT:  bus_rdata = ctrl_q[CTL_RUN] ? cnt_q : reload_q;
        WIX_RELOAD: bus_rdata = reload_q;
        WIX_CTRL:   bus_rdata = {{(WORD_W-CTL_W){1'b0}}, ctrl_q};
        WIX_STATUS: bus_rdata = {{(WORD_W-1){1'b0}}, status_q};
        WIX_ILEN:   bus_rdata = ilen_q;
        WIX_REV:    bus_rdata = REV_CODE;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_checker.sv
`timescale 1ns/1ps
module wdog_checker
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rst_en,
  input logic              expire_evt,
  input logic              load_evt,
  input logic              stop_evt,
  input logic              sclr_evt,
  input logic              armed,
  input logic              sts,
  input logic              rst_req,
  input logic [WORD_W-1:0] cnt,
  input logic [WORD_W-1:0] reload
);
  assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_rst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(expire_evt) && $past(rst_en)));

  assert_status_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> sts);

  assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts) |-> $past(sclr_evt));

  assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cnt == $past(reload)));

  assert_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load_evt) |=> (cnt <= $past(cnt)));

  assert_stop_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !load_evt) |=> !armed);
endmodule

bind wdog_periph wdog_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .rst_en(ctrl_q[1]),
  .expire_evt(expire_evt), .load_evt(load_evt), .stop_evt(stop_evt),
  .sclr_evt(sclr_evt), .armed(armed), .sts(status_q),
  .rst_req(wdt_rst_req), .cnt(cnt_q), .reload(reload_q)
);

// File: tb/wdog_periph_bench.sv
`timescale 1ns/1ps
module wdog_periph_bench;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_irq, wdt_rst_req;

  int checks = 0;
  int errors = 0;
  int rst_pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wdog_periph #(.AW(AW)) u_wdog_periph (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
  );

  always @(negedge clk) if (rst_n && wdt_rst_req) rst_pulses++;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h04, 32'h0,        32'h03EF1480},  // R1 reload reset value
    '{1'b0, 8'h0C, 32'h0,        32'h0},         // R1 control reset
    '{1'b0, 8'h10, 32'h0,        32'h0},         // R1 status reset
    '{1'b0, 8'h1C, 32'h0,        32'h00010601},  // R2 revision
    '{1'b0, 8'h00, 32'h0,        32'h03EF1480},  // R3 disabled count shows reload
    '{1'b1, 8'h40, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 8'h40, 32'h0,        32'h0},         // R2 unmapped
    '{1'b1, 8'h04, 32'h00000010, 32'h0},
    '{1'b0, 8'h04, 32'h0,        32'h00000010},  // R2 reload rw
    '{1'b0, 8'h00, 32'h0,        32'h00000010},  // R3
    '{1'b1, 8'h18, 32'h000000AB, 32'h0},
    '{1'b0, 8'h18, 32'h0,        32'h000000AB},  // R2 interrupt length rw
    '{1'b1, 8'h10, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 8'h10, 32'h0,        32'h0},         // R2 status read-only
    '{1'b1, 8'h0C, 32'hFFFFFFF1, 32'h0},
    '{1'b0, 8'h0C, 32'h0,        32'h00000001},  // R2 control upper bits read 0
    '{1'b0, 8'h00, 32'h0,        32'h00000010}   // R5 enable loads count
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    #0.5;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #0.5;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {31'b0, wdt_irq}, 32'h0);
    chk("R1 rst_req after reset", {31'b0, wdt_rst_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else rd_chk($sformatf("R-table entry %0d", i), VECS[i].addr, VECS[i].exp);
    end

    // R4: five ticks from 0x10
    @(negedge clk); tick_en = 1'b1;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    rd_chk("R4 count after 5 ticks", 8'h00, 32'h0B);
    // R6: wrong key ignored, right key reloads
    wr(8'h08, 32'h00005AB8);
    rd_chk("R6 wrong key ignored", 8'h00, 32'h0B);
    wr(8'h08, 32'h00005AB9);
    rd_chk("R6 key reloads", 8'h00, 32'h10);
    @(negedge clk); tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    // R5: re-enable while running keeps count
    wr(8'h0C, 32'h1);
    rd_chk("R5 re-enable no reload", 8'h00, 32'h0D);
    wr(8'h0C, 32'h0);
    rd_chk("R3 disabled shows reload", 8'h00, 32'h10);

    // R7/R8/R9 exact-cycle expiry
    wr(8'h04, 32'h4);
    p0 = rst_pulses;
    tick_en = 1'b1;
    wr(8'h0C, 32'h7);
    for (int i = 0; i <= 4; i++) begin
      @(negedge clk);
      rd_chk($sformatf("R4 count step %0d", i), 8'h00, 32'(4 - i));
      chk("R7 no early irq", {31'b0, wdt_irq}, 32'h0);
    end
    @(negedge clk);
    chk("R8 rst pulse high", {31'b0, wdt_rst_req}, 32'h1);
    chk("R9 irq raised", {31'b0, wdt_irq}, 32'h1);
    rd_chk("R7 status set", 8'h10, 32'h1);
    @(negedge clk);
    chk("R8 rst pulse one cycle", {31'b0, wdt_rst_req}, 32'h0);
    rd_chk("R4 holds at zero", 8'h00, 32'h0);
    repeat (4) @(negedge clk);
    chk("R7 single expiry", 32'(rst_pulses - p0), 32'h1);

    // R10 clear
    wr(8'h14, 32'hFFFFFFFE);
    rd_chk("R10 clear with bit0=0 ignored", 8'h10, 32'h1);
    wr(8'h14, 32'h1);
    rd_chk("R10 clear", 8'h10, 32'h0);
    chk("R9 irq follows status", {31'b0, wdt_irq}, 32'h0);

    // R9/R8 gating: run only
    wr(8'h0C, 32'h0);
    wr(8'h04, 32'h2);
    p0 = rst_pulses;
    wr(8'h0C, 32'h1);
    repeat (6) @(negedge clk);
    rd_chk("R7 status without irq enable", 8'h10, 32'h1);
    chk("R9 irq gated", {31'b0, wdt_irq}, 32'h0);
    chk("R8 no rst when disabled", 32'(rst_pulses - p0), 32'h0);
    wr(8'h14, 32'h1);

    // R5 stop cancels pending expiry
    wr(8'h0C, 32'h0);
    wr(8'h04, 32'h3);
    p0 = rst_pulses;
    wr(8'h0C, 32'h3);
    @(posedge clk);
    wr(8'h0C, 32'h0);
    repeat (10) @(negedge clk);
    rd_chk("R5 stop cancels expiry", 8'h10, 32'h0);
    chk("R5 no rst after stop", 32'(rst_pulses - p0), 32'h0);
    rd_chk("R3 stopped shows reload", 8'h00, 32'h3);
    tick_en = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule